// File: doc/BRIEF.md
# Pixel Gain, Offset, Clamp and Moment Accumulator

This block sits behind a pixel interpolator and takes one interpolated 8-bit value per clock, together with an 8-bit side parameter that belongs to the same point. Each value is scaled by a programmable fixed-point gain. A programmable signed offset is then added, and the result is clamped back into the 8-bit pixel range. The clamped value feeds three running sums: the plain sum of the values, the sum of their squares, and the sum of each value multiplied by its side parameter. Together these give a correlation routine what it needs from a single pass over a point list.

The sums are exposed as plain output words for a register file to read. They are never cleared by the end of a run, so several runs over different lists or tiles add into the same totals. Software clears them by pulsing a clear input. That clear wins over any sample arriving in the same cycle, and it also discards a sample still inside the block.

Top module: `pga_gain_accum`

## Requirements
- R1: The scaled value is floor(pix * gain / 256) + offset. Gain is unsigned with integer bits [15:8] and fraction bits [7:0]. Offset is a 9-bit two's-complement number.
- R2: A scaled value below 0 becomes 0, and a value above 255 becomes 255, before it is accumulated.
- R3: sum_v accumulates the clamped value of every accepted sample.
- R4: sum_vv accumulates the square of the clamped value of every accepted sample.
- R5: sum_vp accumulates the clamped value times the side parameter p0 of the same sample.
- R6: A sample is accepted on every rising edge where in_valid is high and clr is low, with no gaps needed between samples. Its contribution is visible on the sums after the next rising edge.
- R7: After a rising edge with clr high, all three sums read 0. The sample presented with clr does not contribute, and neither does the sample accepted one edge earlier.
- R8: Without clr, the sums never decrease. They hold their values while no samples arrive and keep adding across runs. A 40-bit sum does not wrap within the supported list lengths.
- R9: While reset is held, and directly after it, all three sums read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_pix | input | 8 | Interpolated pixel value |
| in_p0 | input | 8 | Side parameter of the point |
| gain | input | 16 | Unsigned gain, 8 integer and 8 fraction bits |
| offset | input | 9 | Signed offset |
| clr | input | 1 | Clear all sums; takes priority over samples |
| sum_v | output | 40 | Sum of clamped values |
| sum_vv | output | 40 | Sum of squared clamped values |
| sum_vp | output | 40 | Sum of value times p0 |

## Verification
The bench targets both clamp edges: a large gain pushing the value past 255, and a negative offset pulling it below zero. A design that wrapped instead of clamping would add small or huge values to the sums. Fractional gains check that the fraction is truncated and not rounded. A clear is placed right behind a sample and on the same cycle as another, so a design that only flushed the input, or that let the sample win, would leave a nonzero sum. Idle gaps between runs, and a long stream of full-scale samples, expose sums that drift, wrap or fail to persist.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int PGA_PIX_W  = 8;
  localparam int PGA_N_SUMS = 3;

  typedef enum int {
    SUM_V  = 0,
    SUM_VV = 1,
    SUM_VP = 2
  } sum_sel_e;
endpackage

// File: rtl/pga_rst_sync.sv
module pga_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pga_scale_sat.sv
module pga_scale_sat #(
  parameter int PIX_W     = 8,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int OFS_W     = 9
) (
  input  logic [PIX_W-1:0]         pix,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [OFS_W-1:0]  ofs,
  output logic [PIX_W-1:0]         v_sat
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SH_W   = PROD_W - GAIN_FRAC;
  localparam int SUM_W  = ((SH_W > OFS_W) ? SH_W : OFS_W) + 2;
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PROD_W-1:0]       prod;
  logic [SH_W-1:0]         scaled;
  logic signed [SUM_W-1:0] scaled_s;
  logic signed [SUM_W-1:0] ofs_s;
  logic signed [SUM_W-1:0] total;

  always_comb begin
    prod     = PROD_W'(pix) * PROD_W'(gain);
    scaled   = prod[PROD_W-1:GAIN_FRAC];
    scaled_s = SUM_W'(scaled);
    ofs_s    = SUM_W'(ofs);
    total    = scaled_s + ofs_s;
    if (total < 0) begin
      v_sat = '0;
    end else if (total > PIX_MAX) begin
      v_sat = '1;
    end else begin
      v_sat = total[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/pga_accum.sv
module pga_accum #(
  parameter int ACC_W = 40,
  parameter int IN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IN_W-1:0]  addend,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (add_en) begin
      acc_d = acc_q + ACC_W'(addend);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/pga_gain_accum.sv
module pga_gain_accum
  import pga_pkg::*;
#(
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int OFS_W     = 9,
  parameter int ACC_W     = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PGA_PIX_W-1:0]    in_pix,
  input  logic [PGA_PIX_W-1:0]    in_p0,
  input  logic [GAIN_W-1:0]       gain,
  input  logic signed [OFS_W-1:0] offset,
  input  logic                    clr,
  output logic [ACC_W-1:0]        sum_v,
  output logic [ACC_W-1:0]        sum_vv,
  output logic [ACC_W-1:0]        sum_vp
);
  localparam int ADD_W = 2 * PGA_PIX_W;

  logic                 rst_n_int;
  logic [PGA_PIX_W-1:0] v_comb;

  logic                 vld_q, vld_d;
  logic [PGA_PIX_W-1:0] v_q, v_d;
  logic [PGA_PIX_W-1:0] p0_q, p0_d;
  logic                 stage_en;

  logic                 add_en;
  logic [ADD_W-1:0]     addend [PGA_N_SUMS];
  logic [ACC_W-1:0]     acc    [PGA_N_SUMS];

  pga_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pga_scale_sat #(
    .PIX_W     (PGA_PIX_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .OFS_W     (OFS_W)
  ) scale_i (
    .pix   (in_pix),
    .gain  (gain),
    .ofs   (offset),
    .v_sat (v_comb)
  );

  // stage register: clamped value and its side parameter
  always_comb begin
    stage_en = in_valid & ~clr;
    vld_d    = stage_en;
    v_d      = v_q;
    p0_d     = p0_q;
    if (stage_en) begin
      v_d  = v_comb;
      p0_d = in_p0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      v_q   <= '0;
      p0_q  <= '0;
    end else begin
      vld_q <= vld_d;
      v_q   <= v_d;
      p0_q  <= p0_d;
    end
  end

  // operands of the three sums
  always_comb begin
    add_en         = vld_q & ~clr;
    addend[SUM_V]  = ADD_W'(v_q);
    addend[SUM_VV] = ADD_W'(v_q) * ADD_W'(v_q);
    addend[SUM_VP] = ADD_W'(v_q) * ADD_W'(p0_q);
  end

  for (genvar gi = 0; gi < PGA_N_SUMS; gi++) begin : g_sum
    pga_accum #(
      .ACC_W (ACC_W),
      .IN_W  (ADD_W)
    ) accum_i (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .clr    (clr),
      .add_en (add_en),
      .addend (addend[gi]),
      .acc    (acc[gi])
    );
  end

  assign sum_v  = acc[SUM_V];
  assign sum_vv = acc[SUM_VV];
  assign sum_vp = acc[SUM_VP];
endmodule

// File: rtl/pga_accum_chk.sv
module pga_accum_chk #(
  parameter int ACC_W = 40,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             clr,
  input logic [ACC_W-1:0] sum_v,
  input logic [ACC_W-1:0] sum_vv,
  input logic [ACC_W-1:0] sum_vp
);
  localparam int WIDE_W = ACC_W + PIX_W;
  localparam logic [WIDE_W-1:0] PMAX = WIDE_W'((1 << PIX_W) - 1);

  logic took_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      took_q <= 1'b0;
    end else begin
      took_q <= in_valid & ~clr;
    end
  end

  // R7: a clear leaves all three sums at zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_v == '0 && sum_vv == '0 && sum_vp == '0));

  // R8: no sample in flight and no clear, so the sums hold
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !took_q) |=> ($stable(sum_v) && $stable(sum_vv) && $stable(sum_vp)));

  // R8: without a clear the sums never shrink
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (sum_v >= $past(sum_v) && sum_vv >= $past(sum_vv) && sum_vp >= $past(sum_vp)));

  // R4: each square is at most full scale times the value
  a_r4_square_bound: assert property (@(posedge clk) disable iff (!rst_n)
    WIDE_W'(sum_vv) <= WIDE_W'(sum_v) * PMAX);

  // R5: each product with p0 is at most full scale times the value
  a_r5_param_bound: assert property (@(posedge clk) disable iff (!rst_n)
    WIDE_W'(sum_vp) <= WIDE_W'(sum_v) * PMAX);
endmodule

bind pga_gain_accum pga_accum_chk #(
  .ACC_W (ACC_W),
  .PIX_W (pga_pkg::PGA_PIX_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .clr      (clr),
  .sum_v    (sum_v),
  .sum_vv   (sum_vv),
  .sum_vp   (sum_vp)
);

// File: tb/pga_gain_accum_tb_top.sv
`timescale 1ns/1ps
module pga_gain_accum_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_pix;
  logic [7:0]  in_p0;
  logic [15:0] gain;
  logic [8:0]  offset;
  logic        clr;
  logic [39:0] sum_v, sum_vv, sum_vp;

  int checks = 0;
  int errors = 0;

  // bench model
  longint m_sv, m_svv, m_svp;
  bit     m_vld;
  int     m_v, m_p0;

  pga_gain_accum dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_pix   (in_pix),
    .in_p0    (in_p0),
    .gain     (gain),
    .offset   (offset),
    .clr      (clr),
    .sum_v    (sum_v),
    .sum_vv   (sum_vv),
    .sum_vp   (sum_vp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int f_v(int px, int g, logic [8:0] o);
    int t;
    t = ((px * g) >>> 8) + int'($signed(o));
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit vl, input logic [7:0] px, input logic [7:0] pp);
    clr = c; in_valid = vl; in_pix = px; in_p0 = pp;
    @(posedge clk);
    if (c) begin
      m_sv = 0; m_svv = 0; m_svp = 0; m_vld = 0;
    end else begin
      if (m_vld) begin
        m_sv  += m_v;
        m_svv += m_v * m_v;
        m_svp += m_v * m_p0;
      end
      m_vld = vl;
      if (vl) begin
        m_v  = f_v(int'(px), int'(gain), offset);
        m_p0 = int'(pp);
      end
    end
    @(negedge clk);
    check("R3 sum_v model", longint'(sum_v), m_sv);
    check("R4 sum_vv model", longint'(sum_vv), m_svv);
    check("R5 sum_vp model", longint'(sum_vp), m_svp);
  endtask

  // directed single sample with hand-computed expected value
  task automatic one_sample(input logic [7:0] px, input logic [7:0] pp, input logic [15:0] g,
                            input logic [8:0] o, input int exp_v, input string tag);
    gain = g; offset = o;
    step(1'b1, 1'b0, 8'd0, 8'd0);
    step(1'b0, 1'b1, px, pp);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    check({tag, " sum_v"}, longint'(sum_v), longint'(exp_v));
    check({tag, " sum_vv"}, longint'(sum_vv), longint'(exp_v * exp_v));
    check({tag, " sum_vp"}, longint'(sum_vp), longint'(exp_v) * longint'(pp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint snap;
    void'($urandom(32'h5eed_1234));
    m_sv = 0; m_svv = 0; m_svp = 0; m_vld = 0; m_v = 0; m_p0 = 0;
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_pix = '0; in_p0 = '0;
    gain = 16'h0100; offset = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 sum_v in reset", longint'(sum_v), 0);
    check("R9 sum_vv in reset", longint'(sum_vv), 0);
    check("R9 sum_vp in reset", longint'(sum_vp), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R9 sum_v after reset", longint'(sum_v), 0);

    // R1 unity gain, R3/R4/R5 each sum
    one_sample(8'd100, 8'd3, 16'h0100, 9'd0, 100, "R1 unity");
    // R1 fraction truncated: 3*1.5=4.5 -> 4
    one_sample(8'd3, 8'd7, 16'h0180, 9'd0, 4, "R1 fraction");
    // R1 quarter gain plus offset: 62+10
    one_sample(8'd250, 8'd2, 16'h0040, 9'd10, 72, "R1 quarter");
    // R2 high clamp
    one_sample(8'd200, 8'd1, 16'h0200, 9'd0, 255, "R2 high");
    one_sample(8'd255, 8'd255, 16'hFFFF, 9'h0FF, 255, "R2 max gain");
    // R2 low clamp via negative offset (-5)
    one_sample(8'd77, 8'd9, 16'h0000, 9'h1FB, 0, "R2 low");
    // R2 most negative offset -256 on 255 gives -1 -> 0
    one_sample(8'd255, 8'd9, 16'h0100, 9'h100, 0, "R2 min offset");
    // R1 largest positive offset on zero pixel
    one_sample(8'd0, 8'd4, 16'h0100, 9'h0FF, 255, "R1 offset only");

    // R7: clear behind an in-flight sample and with a new one
    gain = 16'h0100; offset = '0;
    step(1'b1, 1'b0, 8'd0, 8'd0);
    step(1'b0, 1'b1, 8'd100, 8'd1);
    step(1'b1, 1'b1, 8'd50, 8'd1);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R7 clear drops both samples", longint'(sum_v), 0);
    check("R7 clear sum_vp", longint'(sum_vp), 0);

    // R6: back-to-back samples, latency of one edge
    step(1'b0, 1'b1, 8'd10, 8'd2);
    check("R6 not yet visible", longint'(sum_v), 0);
    step(1'b0, 1'b1, 8'd20, 8'd3);
    check("R6 first visible", longint'(sum_v), 10);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R6 both visible", longint'(sum_v), 30);
    check("R5 two products", longint'(sum_vp), 80);

    // R8: hold while idle, then keep adding across runs
    repeat (5) step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R8 idle hold", longint'(sum_v), 30);
    step(1'b0, 1'b1, 8'd5, 8'd0);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R8 second run adds", longint'(sum_v), 35);

    // R8: long full-scale run, no wrap
    step(1'b1, 1'b0, 8'd0, 8'd0);
    for (int i = 0; i < 3000; i++) step(1'b0, 1'b1, 8'd255, 8'd255);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    check("R8 long sum_v", longint'(sum_v), 64'd765000);
    check("R8 long sum_vv", longint'(sum_vv), 64'd195075000);

    // random mix, checked against the model every cycle
    snap = 0;
    for (int i = 0; i < 4000; i++) begin
      if ((i % 97) == 0) begin
        gain   = 16'($urandom_range(0, 16'h03FF));
        offset = 9'($urandom);
      end
      step(($urandom_range(0, 63) == 0), ($urandom_range(0, 3) != 0),
           8'($urandom), 8'($urandom));
      snap++;
    end
    check("R6 random cycles ran", snap, 4000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule